// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block is the receive and address-matching front end of an I2C target. It samples the SCL and SDA lines through a two-flop synchronizer and a stability filter, then finds START, repeated START and STOP conditions. It shifts in address bytes and compares them with an own address that software programs. The own address is either a 7-bit address or a 10-bit address. The 10-bit address is built from a 2-bit high field and an 8-bit low field. When the address matches, the block pulls SDA low in the acknowledge slot and pulses a match interrupt. It then receives data bytes, which it acknowledges or refuses according to a software NAK control bit, or it transmits data bytes supplied by software.

The 10-bit scheme works in three steps. A header byte `11110` carries the two high address bits and the write direction. A second byte carries the low eight bits. A read is started by a repeated START whose header has the read bit set. That read is accepted only after the full address has matched in the write phase just before it. The block drives SDA only through an open-drain enable. It never stretches the clock.

Top module: `i2c_addr_slave`

## Requirements
- R1: A START (filtered SDA falls while filtered SCL is high) restarts address reception from any state, including in the middle of a byte. A STOP (SDA rises while SCL is high) releases SDA, withdraws 10-bit read permission and returns the block to idle. After reset, `sda_oe_o` is 0, all interrupt pulses are low and `rx_data_o` is 0.
- R2: When `ten_bit_i`=0, bits [7:1] of the first byte after START are compared with `addr_lo_i[6:0]`, and bit 0 is the direction (1 = read). On a match the block acknowledges and pulses `match_irq_o` once. A read then transmits and a write then receives.
- R3: When `ten_bit_i`=1, a first byte equal to `11110`, `addr_hi_i[1:0]`, 0 is acknowledged without a match pulse. The next byte is acknowledged, with one `match_irq_o` pulse, only if it equals `addr_lo_i`.
- R4: When `ten_bit_i`=1, a header `11110`, `addr_hi_i`, 1 is acknowledged, with a match pulse, only if the full 10-bit address matched since the last STOP and the header arrives after a repeated START. Otherwise it is not acknowledged.
- R5: An address byte that does not match is not acknowledged. All later bytes are then ignored (no acknowledge, no pulses) until the next START.
- R6: An acknowledge holds `sda_oe_o`=1 for the whole high period of the ninth SCL pulse. `sda_oe_o` changes only in the cycle after a filtered SCL falling edge, a START or a STOP.
- R7: After the eighth bit of a received data byte, `rx_data_o` takes the byte (MSB first) and `rx_irq_o` pulses once. The acknowledge slot is driven low if `nak_i`=0 and left released if `nak_i`=1.
- R8: In a read, `tx_data_i` is loaded at the start of each byte and shifted out MSB first. A master acknowledge leads to the next byte. A master NAK pulses `nak_irq_o` and releases SDA until the next START or STOP.
- R9: `match_irq_o`, `rx_irq_o` and `nak_irq_o` are single-cycle pulses, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| ten_bit_i | input | 1 | 1 selects 10-bit addressing |
| addr_hi_i | input | 2 | High two bits of the 10-bit own address |
| addr_lo_i | input | 8 | Low eight address bits; [6:0] in 7-bit mode |
| nak_i | input | 1 | 1 refuses received data bytes |
| tx_data_i | input | 8 | Byte to transmit in a read |
| rx_data_o | output | 8 | Last received data byte |
| match_irq_o | output | 1 | Own-address match pulse |
| rx_irq_o | output | 1 | Data byte received pulse |
| nak_irq_o | output | 1 | Master refused a transmitted byte |

## Verification
Some rules are checked by assertions on every cycle. SDA may change only after an SCL fall or a bus condition. SDA is released after a STOP and after a master NAK. Every match pulse coincides with the acknowledge being driven, and the acknowledge of a received byte follows the NAK control. The interrupt pulses stay one cycle wide and do not overlap. Other behaviours need bus scenarios, and only the bench's reference model can show them. These are the 10-bit header and low-byte sequence, the read permission that lasts across a repeated START but not across a STOP, the ignoring of the bus after a mismatch, and the byte values in both directions.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam int HI_W   = 2;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [CNT_W-1:0]  bitcnt_t;
    typedef logic [HI_W-1:0]   ahi_t;

    localparam bitcnt_t CNT_ONE  = bitcnt_t'(1);
    localparam bitcnt_t CNT_FULL = bitcnt_t'(BYTE_W);
    localparam logic [4:0] HDR10 = 5'b11110;

    typedef enum logic [3:0] {
        ST_WAIT,
        ST_ADDR1,
        ST_ADDR2,
        ST_ACK_HDR,
        ST_ACK_MATCH,
        ST_RX,
        ST_ACK_RX,
        ST_TX,
        ST_TX_ACK
    } slv_st_t;

    typedef struct packed {
        slv_st_t st;
        bitcnt_t cnt;
        byte_t   sh;
        byte_t   tx;
        byte_t   rx_data;
        logic    oe;
        logic    rw;
        logic    armed;
        logic    m_ack;
        logic    match_p;
        logic    rx_p;
        logic    nak_p;
    } slv_regs_t;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic          filt;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d      = flt_q;
        flt_d.sync = {flt_q.sync[0], line_i};
        if (flt_q.sync[1] == flt_q.filt) begin
            flt_d.cnt = '0;
        end else if (flt_q.cnt == CW'(FILT_LEN - 1)) begin
            flt_d.filt = flt_q.sync[1];
            flt_d.cnt  = '0;
        end else begin
            flt_d.cnt = flt_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q <= '{sync: 2'b11, filt: 1'b1, cnt: '0};
        end else begin
            flt_q <= flt_d;
        end
    end

    assign line_o = flt_q.filt;

    // R1: the filtered level only moves to a value the synchronizer already held
    p_filt_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o != $past(line_o)) |-> ($past(flt_q.sync[1]) == line_o))
        else $error("filtered line moved without synchronized support");
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d     = prev_q;
        prev_d.scl = scl_f;
        prev_d.sda = sda_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '{scl: 1'b1, sda: 1'b1};
        else        prev_q <= prev_d;
    end

    assign scl_rise  = scl_f && !prev_q.scl;
    assign scl_fall  = !scl_f && prev_q.scl;
    assign bus_start = scl_f && prev_q.scl && prev_q.sda && !sda_f;
    assign bus_stop  = scl_f && prev_q.scl && !prev_q.sda && sda_f;
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_slv_pkg::*;
(
    input  byte_t byte_i,
    input  ahi_t  hi_i,
    input  byte_t lo_i,
    output logic  hit7_o,
    output logic  hdr_o,
    output logic  lo_hit_o
);
    always_comb begin
        hit7_o   = (byte_i[BYTE_W-1:1] == lo_i[BYTE_W-2:0]);
        hdr_o    = (byte_i[7:3] == HDR10) && (byte_i[2:1] == hi_i);
        lo_hit_o = (byte_i == lo_i);
    end
endmodule

// File: rtl/i2c_addr_slave.sv
module i2c_addr_slave
    import i2c_slv_pkg::*;
#(
    parameter int FILT_LEN = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic       ten_bit_i,
    input  logic [1:0] addr_hi_i,
    input  logic [7:0] addr_lo_i,
    input  logic       nak_i,
    input  logic [7:0] tx_data_i,
    output logic [7:0] rx_data_o,
    output logic       match_irq_o,
    output logic       rx_irq_o,
    output logic       nak_irq_o
);
    logic scl_f, sda_f;
    logic ev_rise, ev_fall, ev_start, ev_stop;
    logic hit7, hdr_hit, lo_hit;

    i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_scl_flt (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_f)
    );
    i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_sda_flt (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_f)
    );

    i2c_bus_events u_events (
        .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
        .scl_rise(ev_rise), .scl_fall(ev_fall),
        .bus_start(ev_start), .bus_stop(ev_stop)
    );

    slv_regs_t r_d, r_q;

    i2c_addr_match u_match (
        .byte_i(r_q.sh), .hi_i(addr_hi_i), .lo_i(addr_lo_i),
        .hit7_o(hit7), .hdr_o(hdr_hit), .lo_hit_o(lo_hit)
    );

    always_comb begin
        r_d         = r_q;
        r_d.match_p = 1'b0;
        r_d.rx_p    = 1'b0;
        r_d.nak_p   = 1'b0;
        if (ev_stop) begin
            r_d.st    = ST_WAIT;
            r_d.oe    = 1'b0;
            r_d.armed = 1'b0;
            r_d.cnt   = '0;
        end else if (ev_start) begin
            r_d.st  = ST_ADDR1;
            r_d.oe  = 1'b0;
            r_d.cnt = '0;
        end else begin
            unique case (r_q.st)
                ST_ADDR1, ST_ADDR2, ST_RX: begin
                    if (ev_rise && r_q.cnt < CNT_FULL) begin
                        r_d.sh  = {r_q.sh[BYTE_W-2:0], sda_f};
                        r_d.cnt = r_q.cnt + CNT_ONE;
                    end else if (ev_fall && r_q.cnt == CNT_FULL) begin
                        r_d.cnt = '0;
                        r_d.st  = ST_WAIT;
                        if (r_q.st == ST_RX) begin
                            r_d.rx_data = r_q.sh;
                            r_d.rx_p    = 1'b1;
                            r_d.oe      = !nak_i;
                            r_d.st      = ST_ACK_RX;
                        end else if (r_q.st == ST_ADDR2) begin
                            if (lo_hit) begin
                                r_d.oe      = 1'b1;
                                r_d.armed   = 1'b1;
                                r_d.rw      = 1'b0;
                                r_d.match_p = 1'b1;
                                r_d.st      = ST_ACK_MATCH;
                            end else begin
                                r_d.armed = 1'b0;
                            end
                        end else if (!ten_bit_i) begin
                            if (hit7) begin
                                r_d.oe      = 1'b1;
                                r_d.rw      = r_q.sh[0];
                                r_d.match_p = 1'b1;
                                r_d.st      = ST_ACK_MATCH;
                            end
                        end else if (hdr_hit && !r_q.sh[0]) begin
                            r_d.oe    = 1'b1;
                            r_d.armed = 1'b0;
                            r_d.st    = ST_ACK_HDR;
                        end else if (hdr_hit && r_q.armed) begin
                            r_d.oe      = 1'b1;
                            r_d.rw      = 1'b1;
                            r_d.match_p = 1'b1;
                            r_d.st      = ST_ACK_MATCH;
                        end else begin
                            r_d.armed = 1'b0;
                        end
                    end
                end
                ST_ACK_HDR: begin
                    if (ev_fall) begin
                        r_d.oe = 1'b0;
                        r_d.st = ST_ADDR2;
                    end
                end
                ST_ACK_RX: begin
                    if (ev_fall) begin
                        r_d.oe = 1'b0;
                        r_d.st = ST_RX;
                    end
                end
                ST_ACK_MATCH: begin
                    if (ev_fall) begin
                        if (r_q.rw) begin
                            r_d.tx  = tx_data_i;
                            r_d.oe  = !tx_data_i[BYTE_W-1];
                            r_d.cnt = '0;
                            r_d.st  = ST_TX;
                        end else begin
                            r_d.oe = 1'b0;
                            r_d.st = ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (ev_rise) begin
                        r_d.cnt = r_q.cnt + CNT_ONE;
                    end else if (ev_fall) begin
                        if (r_q.cnt == CNT_FULL) begin
                            r_d.oe  = 1'b0;
                            r_d.cnt = '0;
                            r_d.st  = ST_TX_ACK;
                        end else if (r_q.cnt != '0) begin
                            r_d.tx = {r_q.tx[BYTE_W-2:0], 1'b0};
                            r_d.oe = !r_q.tx[BYTE_W-2];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (ev_rise) begin
                        r_d.m_ack = !sda_f;
                    end else if (ev_fall) begin
                        if (r_q.m_ack) begin
                            r_d.tx  = tx_data_i;
                            r_d.oe  = !tx_data_i[BYTE_W-1];
                            r_d.cnt = '0;
                            r_d.st  = ST_TX;
                        end else begin
                            r_d.nak_p = 1'b1;
                            r_d.oe    = 1'b0;
                            r_d.st    = ST_WAIT;
                        end
                    end
                end
                default: begin
                    r_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_WAIT, cnt: '0, sh: '0, tx: '0, rx_data: '0,
                     oe: 1'b0, rw: 1'b0, armed: 1'b0, m_ack: 1'b0,
                     match_p: 1'b0, rx_p: 1'b0, nak_p: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe_o    = r_q.oe;
    assign rx_data_o   = r_q.rx_data;
    assign match_irq_o = r_q.match_p;
    assign rx_irq_o    = r_q.rx_p;
    assign nak_irq_o   = r_q.nak_p;

    // R6: SDA drive changes only after an SCL fall or a bus condition
    p_oe_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> $past(ev_fall || ev_start || ev_stop))
        else $error("SDA drive changed outside SCL low phase");

    // R1: STOP releases SDA
    p_stop_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> !sda_oe_o)
        else $error("SDA still driven after STOP");

    // R2: every match pulse comes with the acknowledge driven
    p_match_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        match_irq_o |-> sda_oe_o)
        else $error("match without acknowledge");

    // R5: while ignoring the bus the block never drives SDA
    p_wait_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT) |-> !sda_oe_o)
        else $error("SDA driven while ignoring bus");

    // R7: received-byte acknowledge follows the NAK control
    p_rx_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq_o |-> (sda_oe_o == !$past(nak_i)))
        else $error("data acknowledge disagrees with NAK control");

    // R8: master NAK leaves SDA released
    p_nak_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        nak_irq_o |-> !sda_oe_o)
        else $error("SDA driven after master NAK");

    // R9: pulses are exclusive and one cycle wide
    p_irq_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({match_irq_o, rx_irq_o, nak_irq_o}))
        else $error("overlapping interrupt pulses");
    p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (match_irq_o || rx_irq_o || nak_irq_o) |=> !(match_irq_o || rx_irq_o || nak_irq_o))
        else $error("interrupt pulse longer than one cycle");
endmodule

// File: tb/i2c_addr_slave_tb.sv
`timescale 1ns/1ps
module i2c_addr_slave_tb;
    localparam int Q = 16;
    localparam int PH_IGN = 0, PH_A1 = 1, PH_A2 = 2, PH_RX = 3, PH_TX = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic ten = 1'b0, nak = 1'b0;
    logic [1:0] hi = 2'b00;
    logic [7:0] lo = 8'h00, txd = 8'h00;
    logic sda_oe_o, match_irq_o, rx_irq_o, nak_irq_o;
    logic [7:0] rx_data_o;
    wire  sda_bus = m_sda & ~sda_oe_o;

    int checks = 0, fails = 0;
    int n_match = 0, n_rx = 0, n_nak = 0, n_wide = 0;
    int exp_match = 0, exp_rx = 0, exp_nak = 0;
    int ph = PH_IGN;
    bit armed = 1'b0;
    bit chk_en = 1'b0, exp_oe = 1'b0, done = 1'b0;
    logic [7:0] last_rx = 8'h00;

    always #4 clk = ~clk;

    i2c_addr_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_oe_o(sda_oe_o), .ten_bit_i(ten), .addr_hi_i(hi), .addr_lo_i(lo),
        .nak_i(nak), .tx_data_i(txd), .rx_data_o(rx_data_o),
        .match_irq_o(match_irq_o), .rx_irq_o(rx_irq_o), .nak_irq_o(nak_irq_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison of the SDA drive against the reference model
    bit any_p = 1'b0;
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (match_irq_o) n_match++;
            if (rx_irq_o) n_rx++;
            if (nak_irq_o) n_nak++;
            if (any_p && (match_irq_o || rx_irq_o || nak_irq_o)) n_wide++;
            any_p = match_irq_o || rx_irq_o || nak_irq_o;
            if (chk_en && m_scl && (sda_oe_o !== exp_oe))
                chk(1'b0, "R6 per-clock SDA drive", int'(sda_oe_o), int'(exp_oe));
        end
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        if (!m_scl) begin
            wclk(Q); m_sda = 1'b1; wclk(Q); m_scl = 1'b1;
        end
        exp_oe = 1'b0; chk_en = 1'b1;
        wclk(Q); m_sda = 1'b0; wclk(Q); m_scl = 1'b0; chk_en = 1'b0;
        ph = PH_A1;
    endtask

    task automatic bus_stop();
        wclk(Q); m_sda = 1'b0; wclk(Q); m_scl = 1'b1;
        exp_oe = 1'b0; chk_en = 1'b1;
        wclk(Q); m_sda = 1'b1; wclk(Q); chk_en = 1'b0;
        ph = PH_IGN; armed = 1'b0;
    endtask

    task automatic put_bit(input logic b);
        wclk(Q); m_sda = b; wclk(Q);
        exp_oe = 1'b0; chk_en = 1'b1; m_scl = 1'b1;
        wclk(2*Q); m_scl = 1'b0; chk_en = 1'b0;
    endtask

    task automatic get_bit(input bit e, output logic b);
        wclk(Q); m_sda = 1'b1; wclk(Q);
        exp_oe = e; chk_en = 1'b1; m_scl = 1'b1;
        wclk(Q); b = sda_bus; wclk(Q); m_scl = 1'b0; chk_en = 0;
    endtask

    // behavioural reference: expected acknowledge for a byte the master writes
    task automatic mdl_byte(input logic [7:0] b, output bit ack);
        ack = 1'b0;
        case (ph)
            PH_A1: begin
                if (!ten) begin
                    if (b[7:1] == lo[6:0]) begin
                        ack = 1'b1; exp_match++; ph = b[0] ? PH_TX : PH_RX;
                    end else ph = PH_IGN;
                end else if (b[7:3] == 5'b11110 && b[2:1] == hi && !b[0]) begin
                    ack = 1'b1; armed = 1'b0; ph = PH_A2;
                end else if (b[7:3] == 5'b11110 && b[2:1] == hi && armed) begin
                    ack = 1'b1; exp_match++; ph = PH_TX;
                end else begin
                    armed = 1'b0; ph = PH_IGN;
                end
            end
            PH_A2: begin
                if (b == lo) begin
                    ack = 1'b1; armed = 1'b1; exp_match++; ph = PH_RX;
                end else begin
                    armed = 1'b0; ph = PH_IGN;
                end
            end
            PH_RX: begin
                exp_rx++; last_rx = b; ack = !nak;
            end
            default: ack = 1'b0;
        endcase
    endtask

    task automatic wr_byte(input logic [7:0] b, input string tag);
        bit e;
        logic a0, a1;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        mdl_byte(b, e);
        wclk(Q); m_sda = 1'b1; wclk(Q);
        exp_oe = e; chk_en = 1'b1; m_scl = 1'b1;
        wclk(2); a0 = sda_bus; wclk(2*Q - 4); a1 = sda_bus; wclk(2);
        m_scl = 1'b0; chk_en = 1'b0;
        chk(a0 == a1, {tag, " R6 ack level held over high period"}, int'(a1), int'(a0));
        chk((!a0) == e, {tag, " acknowledge"}, int'(!a0), int'(e));
    endtask

    task automatic rd_byte(input bit mack, input logic [7:0] next_tx, input string tag);
        logic [7:0] got, expb;
        logic b;
        bit live;
        live = (ph == PH_TX);
        expb = live ? txd : 8'hFF;
        for (int i = 7; i >= 0; i--) begin
            get_bit(live ? !expb[i] : 1'b0, b);
            got[i] = b;
        end
        wclk(Q); m_sda = !mack; txd = next_tx; wclk(Q);
        exp_oe = 1'b0; chk_en = 1'b1; m_scl = 1'b1;
        wclk(2*Q); m_scl = 1'b0; chk_en = 1'b0;
        if (live && !mack) begin
            ph = PH_IGN; exp_nak++;
        end
        chk(got == expb, {tag, " read byte"}, int'(got), int'(expb));
    endtask

    task automatic check_counts(input string tag);
        wclk(4);
        chk(n_match == exp_match, {tag, " R2/R3/R4 match pulses"}, n_match, exp_match);
        chk(n_rx == exp_rx, {tag, " R7 rx pulses"}, n_rx, exp_rx);
        chk(n_nak == exp_nak, {tag, " R8 nak pulses"}, n_nak, exp_nak);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        wclk(5); rst_n = 1'b1; wclk(20);
        // R1: reset state
        chk(sda_oe_o == 1'b0, "R1 reset sda_oe_o", int'(sda_oe_o), 0);
        chk(rx_data_o == 8'h00, "R1 reset rx_data_o", int'(rx_data_o), 0);
        chk({match_irq_o, rx_irq_o, nak_irq_o} == 3'b000, "R1 reset pulses",
            int'({match_irq_o, rx_irq_o, nak_irq_o}), 0);

        // R2/R7: 7-bit write, address 0x5A
        ten = 1'b0; lo = 8'h5A;
        bus_start();
        wr_byte(8'hB4, "R2 7-bit write addr");
        wr_byte(8'h3C, "R7 data1");
        chk(rx_data_o == last_rx, "R7 rx_data first", int'(rx_data_o), int'(last_rx));
        wr_byte(8'hA5, "R7 data2");
        chk(rx_data_o == last_rx, "R7 rx_data second", int'(rx_data_o), int'(last_rx));
        bus_stop();
        chk(sda_oe_o == 1'b0, "R1 released after STOP", int'(sda_oe_o), 0);
        check_counts("7-bit write");

        // R7: NAK control refuses data
        nak = 1'b1;
        bus_start();
        wr_byte(8'hB4, "R2 addr");
        wr_byte(8'h0F, "R7 nak data");
        chk(rx_data_o == 8'h0F, "R7 rx_data with nak", int'(rx_data_o), 8'h0F);
        nak = 1'b0;
        bus_stop();
        check_counts("nak write");

        // R8: 7-bit read, master ack then nak, then extra clocks ignored
        txd = 8'hC3;
        bus_start();
        wr_byte(8'hB5, "R2 7-bit read addr");
        rd_byte(1'b1, 8'h5E, "R8 byte1");
        rd_byte(1'b0, 8'h77, "R8 byte2 nak");
        rd_byte(1'b0, 8'h77, "R8 after nak released");
        bus_stop();
        check_counts("7-bit read");

        // R5: mismatch, then own address without START ignored
        bus_start();
        wr_byte(8'h44, "R5 mismatch");
        wr_byte(8'hB4, "R5 ignored after mismatch");
        bus_stop();
        check_counts("mismatch");

        // R1: START in the middle of a byte restarts reception
        bus_start();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_start();
        wr_byte(8'hB4, "R1 restart mid-byte");
        bus_stop();
        check_counts("restart");

        // R3/R4: 10-bit write then repeated-START read
        ten = 1'b1; hi = 2'b10; lo = 8'h67;
        bus_start();
        wr_byte(8'hF4, "R3 header write");
        chk(n_match == exp_match, "R3 no match on header", n_match, exp_match);
        wr_byte(8'h67, "R3 low byte");
        wr_byte(8'h81, "R7 10-bit data");
        chk(rx_data_o == 8'h81, "R7 10-bit rx_data", int'(rx_data_o), 8'h81);
        txd = 8'h99;
        bus_start();
        wr_byte(8'hF5, "R4 header read armed");
        rd_byte(1'b0, 8'h00, "R8 10-bit read");
        bus_stop();
        check_counts("10-bit");

        // R4: read header after STOP is refused
        bus_start();
        wr_byte(8'hF5, "R4 header read unarmed");
        bus_stop();

        // R5: wrong high bits, wrong low byte
        bus_start();
        wr_byte(8'hF0, "R5 wrong header");
        bus_stop();
        bus_start();
        wr_byte(8'hF4, "R3 header");
        wr_byte(8'h66, "R5 wrong low byte");
        wr_byte(8'h67, "R5 ignored after low mismatch");
        bus_stop();
        check_counts("10-bit negative");

        chk(n_wide == 0, "R9 pulse width/overlap", n_wide, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule